// File: doc/BRIEF.md
# Per-Stream Serial Output Advance Timer

This block times the serial outputs of a set of frame-aligned TDM streams. It runs from a fine step clock at sixteen times the 8.192 Mb/s bit rate, so one step is 1/16 of an 8 Mb/s bit cell. A frame pulse clears a frame-phase counter that counts these steps. Each stream is clocked at 8 Mb/s (a new bit every 16 steps) or at 16 Mb/s (a new bit every 8 steps). A 2-bit code makes the stream launch every bit 0 to 3 steps before its nominal boundary. A code of zero keeps the output aligned with the frame pulse. At 8 Mb/s each step is 1/16 of a bit, and at 16 Mb/s it is 1/8 of a bit.

A host writes the codes into four 16-bit registers, each holding the codes for eight streams. A written value is held in a staging copy and becomes active only at the next frame pulse, so no bit cell is cut short or repeated in the middle of a frame. The parallel bit source is one byte per stream, sent most significant bit first. Each output has a strobe that marks the step in which a new bit first appears.

Top module: `stream_advance_timer`

## Requirements
- R1: After reset, all four code registers read 0x0000, and every `ser_o` and `launch_o` bit is 0.
- R2: Word addresses 0x1C, 0x1D, 0x1E and 0x1F hold the codes for streams 0-7, 8-15, 16-23 and 24-31. Stream n uses bits [2k+1:2k] of its register, where k = n mod 8. A write is visible on `host_rdata_o` in the next cycle. A write to any other address changes nothing, and such an address reads 0.
- R3: The frame pulse, sampled at a clock edge, sets the phase to 0 for the next cycle, even in the middle of a frame. Otherwise the phase counts up by one each step and wraps at FRAME_BITS*16.
- R4: At 8 Mb/s with code 0, a stream launches a bit exactly in the cycles where phase mod 16 = 0.
- R5: At 8 Mb/s with code k, a stream launches exactly in the cycles where (phase + k) mod 16 = 0. Each bit is therefore k/16 of a bit cell early.
- R6: At 16 Mb/s (`rate16_i[n]` = 1) with code k, a stream launches exactly in the cycles where (phase + k) mod 8 = 0. Each bit is therefore k/8 of a bit cell early.
- R7: For a launch at phase p, let a = (p + k) mod frame length and P the step period. The bit driven is bit 7 - ((a / P) mod 8) of the stream's byte. So with k > 0, bit 7 of the first slot of the next frame starts k steps before the frame pulse.
- R8: A code written in the middle of a frame does not change the stream's timing until the next frame pulse.
- R9: A stream's `ser_o` changes value only in a cycle where its `launch_o` is 1.
- R10: The streams are timed independently: one stream's code and rate do not affect another stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fine step clock, 16 steps per 8 Mb/s bit |
| rst_ni | input | 1 | Synchronous active-low reset |
| frame_i | input | 1 | Frame pulse, one step wide |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | ADDR_W | Host word address for both read and write |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Staged register at `host_addr_i`, 0 outside the window |
| rate16_i | input | NUM_STREAMS | Per stream: 1 = 16 Mb/s, 0 = 8 Mb/s |
| tx_byte_i | input | NUM_STREAMS*8 | Parallel byte source, stream n at [8n+7:8n] |
| ser_o | output | NUM_STREAMS | Serial outputs |
| launch_o | output | NUM_STREAMS | High in the step where a new bit first appears |

## Verification
Single streams are run through whole frames with each of the four codes, at both rates. Streams are chosen in different registers and at the lowest and highest field positions, so a wrong field position or a wrong step period shows up as a launch in the wrong cycle. A frame pulse that arrives early separates a phase counter that clears on the pulse from one that only wraps. A code written in the middle of a frame, and checked against the old timing until the next pulse, separates the staged update from an immediate one. Every launch is compared with the expected byte bit, which also catches a wrong bit order or a missed slot wrap ahead of the frame pulse.

// File: rtl/sat_pkg.sv
// Shared constants for the per-stream serial output advance timer.
// Assumes the fine step clock runs at 16 steps per 8 Mb/s bit cell.
package sat_pkg;
    localparam int ADV_CODE_W    = 2;   // width of one stream's advance code
    localparam int STEPS_8M      = 16;  // steps per bit cell at 8 Mb/s
    localparam int STEPS_16M     = 8;   // steps per bit cell at 16 Mb/s
    localparam int BITS_PER_BYTE = 8;   // bits in one channel byte
endpackage

// File: rtl/sat_phase.sv
// Frame-phase counter in fine steps.
// Counts 0..FRAME_STEPS-1 and is cleared by the frame pulse. It also
// gives the value the counter takes at the next edge, which the lanes use
// to register their outputs in the matching cycle.
module sat_phase #(
    parameter int FRAME_STEPS = 16384,
    parameter int PH_W        = 14
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            frame_i,
    output logic [PH_W-1:0] phase_q,
    output logic [PH_W-1:0] phase_nxt
);
    // Next phase: cleared by the pulse, otherwise count and wrap.
    always_comb begin
        if (frame_i) begin
            phase_nxt = '0;
        end else if (phase_q == PH_W'(FRAME_STEPS - 1)) begin
            phase_nxt = '0;
        end else begin
            phase_nxt = phase_q + 1'b1;
        end
    end

    // Phase register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_nxt;
        end
    end
endmodule

// File: rtl/sat_regbank.sv
// Host code registers with a staging copy and an active copy.
// Writes land in the staging copy. The active copy takes the staging copy
// at each frame pulse. Reads return the staging copy.
// Assumes NUM_REGS >= 2.
module sat_regbank #(
    parameter int NUM_REGS  = 4,
    parameter int REG_W     = 16,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 28
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      frame_i,
    input  logic                      wr_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [REG_W-1:0]          wdata_i,
    output logic [REG_W-1:0]          rdata_o,
    output logic [NUM_REGS*REG_W-1:0] cfg_o,
    output logic [NUM_REGS*REG_W-1:0] act_o
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0][REG_W-1:0] cfg_q;
    logic [NUM_REGS-1:0][REG_W-1:0] act_q;
    logic [ADDR_W-1:0]              off;
    logic                           hit;
    logic [IDX_W-1:0]               idx;

    // Address decode: offset from the base, and whether it is in the window.
    always_comb off = addr_i - ADDR_W'(BASE_ADDR);
    always_comb hit = ({1'b0, off} < (ADDR_W + 1)'(NUM_REGS));
    always_comb idx = off[IDX_W-1:0];

    // Staging registers: host writes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (wr_i && hit && (idx == IDX_W'(r))) begin
                    cfg_q[r] <= wdata_i;
                end
            end
        end
    end

    // Active registers: load the staging copy at the frame pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            act_q <= '0;
        end else if (frame_i) begin
            act_q <= cfg_q;
        end
    end

    // Read mux.
    always_comb rdata_o = hit ? cfg_q[idx] : '0;

    assign cfg_o = cfg_q;
    assign act_o = act_q;
endmodule

// File: rtl/sat_lane.sv
// One stream's launch timing.
// Launches a bit at the edge where the next phase plus the code lands on a
// nominal boundary, and picks the byte bit from the slot number.
// Assumes FRAME_STEPS is a multiple of 16.
module sat_lane
    import sat_pkg::*;
#(
    parameter int FRAME_STEPS = 16384,
    parameter int PH_W        = 14
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [PH_W-1:0]       phase_nxt_i,
    input  logic [ADV_CODE_W-1:0] code_i,
    input  logic                  rate16_i,
    input  logic [7:0]            byte_i,
    output logic                  ser_o,
    output logic                  launch_o
);
    localparam int AW = PH_W + 1;

    logic [AW-1:0] ahead_raw;
    logic [AW-1:0] ahead;
    logic [AW-1:0] slot;
    logic          on_edge;
    logic [2:0]    pos;

    // Phase shifted ahead by the code, taken modulo the frame length.
    always_comb ahead_raw = {1'b0, phase_nxt_i} + AW'(code_i);
    always_comb ahead = (ahead_raw >= AW'(FRAME_STEPS))
                      ? ahead_raw - AW'(FRAME_STEPS) : ahead_raw;

    // Boundary test and slot number for the selected rate.
    always_comb begin
        if (rate16_i) begin
            on_edge = (ahead % AW'(STEPS_16M)) == '0;
            slot    = ahead / AW'(STEPS_16M);
        end else begin
            on_edge = (ahead % AW'(STEPS_8M)) == '0;
            slot    = ahead / AW'(STEPS_8M);
        end
    end

    // Bit position within the byte, sent most significant bit first.
    always_comb pos = 3'(slot % AW'(BITS_PER_BYTE));

    // Output register and launch strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ser_o    <= 1'b0;
            launch_o <= 1'b0;
        end else begin
            launch_o <= on_edge;
            if (on_edge) begin
                ser_o <= byte_i[3'd7 - pos];
            end
        end
    end
endmodule

// File: rtl/stream_advance_timer.sv
// Top level: one frame-phase counter, one code register bank, and one
// timing lane per stream. Stream n's code sits at bits [2n+1:2n] of the
// concatenated registers. At the pulse edge the lanes see the staged
// codes, so a new code also governs the launch at phase 0.
module stream_advance_timer
    import sat_pkg::*;
#(
    parameter int NUM_STREAMS = 32,
    parameter int REG_W       = 16,
    parameter int ADDR_W      = 8,
    parameter int BASE_ADDR   = 28,
    parameter int FRAME_BITS  = 1024
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     frame_i,
    input  logic                     host_wr_i,
    input  logic [ADDR_W-1:0]        host_addr_i,
    input  logic [REG_W-1:0]         host_wdata_i,
    output logic [REG_W-1:0]         host_rdata_o,
    input  logic [NUM_STREAMS-1:0]   rate16_i,
    input  logic [NUM_STREAMS*8-1:0] tx_byte_i,
    output logic [NUM_STREAMS-1:0]   ser_o,
    output logic [NUM_STREAMS-1:0]   launch_o
);
    localparam int STREAMS_PER_REG = REG_W / ADV_CODE_W;
    localparam int NUM_REGS        = NUM_STREAMS / STREAMS_PER_REG;
    localparam int FRAME_STEPS     = FRAME_BITS * STEPS_8M;
    localparam int PH_W            = $clog2(FRAME_STEPS);

    logic [PH_W-1:0]           phase_q;
    logic [PH_W-1:0]           phase_nxt;
    logic [NUM_REGS*REG_W-1:0] cfg_flat;
    logic [NUM_REGS*REG_W-1:0] act_flat;
    logic [NUM_REGS*REG_W-1:0] eff_flat;

    sat_phase #(
        .FRAME_STEPS (FRAME_STEPS),
        .PH_W        (PH_W)
    ) u_phase (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .frame_i   (frame_i),
        .phase_q   (phase_q),
        .phase_nxt (phase_nxt)
    );

    sat_regbank #(
        .NUM_REGS  (NUM_REGS),
        .REG_W     (REG_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .frame_i (frame_i),
        .wr_i    (host_wr_i),
        .addr_i  (host_addr_i),
        .wdata_i (host_wdata_i),
        .rdata_o (host_rdata_o),
        .cfg_o   (cfg_flat),
        .act_o   (act_flat)
    );

    // Codes in force at this edge: staged ones at a pulse, else active ones.
    always_comb eff_flat = frame_i ? cfg_flat : act_flat;

    for (genvar n = 0; n < NUM_STREAMS; n++) begin : g_lane
        sat_lane #(
            .FRAME_STEPS (FRAME_STEPS),
            .PH_W        (PH_W)
        ) u_lane (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .phase_nxt_i (phase_nxt),
            .code_i      (eff_flat[n*ADV_CODE_W +: ADV_CODE_W]),
            .rate16_i    (rate16_i[n]),
            .byte_i      (tx_byte_i[n*8 +: 8]),
            .ser_o       (ser_o[n]),
            .launch_o    (launch_o[n])
        );
    end
endmodule

// File: rtl/sat_checker.sv
// Temporal checks for stream_advance_timer, attached with bind.
// Assumes the same parameters as the instance it is bound to.
module sat_checker #(
    parameter int NUM_STREAMS = 32,
    parameter int REG_W       = 16,
    parameter int ADDR_W      = 8,
    parameter int BASE_ADDR   = 28,
    parameter int NUM_REGS    = 4,
    parameter int FRAME_STEPS = 16384,
    parameter int PH_W        = 14
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      frame_i,
    input logic                      host_wr_i,
    input logic [ADDR_W-1:0]         host_addr_i,
    input logic [REG_W-1:0]          host_wdata_i,
    input logic [REG_W-1:0]          host_rdata_o,
    input logic [NUM_STREAMS-1:0]    ser_o,
    input logic [NUM_STREAMS-1:0]    launch_o,
    input logic [PH_W-1:0]           phase_i,
    input logic [NUM_REGS*REG_W-1:0] act_i
);
    logic [ADDR_W-1:0] off;
    logic              in_win;

    // Independent window decode for the read-back check.
    always_comb off = host_addr_i - ADDR_W'(BASE_ADDR);
    always_comb in_win = ({1'b0, off} < (ADDR_W + 1)'(NUM_REGS));

    // R3: the pulse clears the phase.
    assert_phase_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_i |=> (phase_i == '0));

    // R3: without a pulse the phase counts up by one.
    assert_phase_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!frame_i && (phase_i != PH_W'(FRAME_STEPS - 1)))
        |=> (phase_i == $past(phase_i) + 1'b1));

    // R8: active codes stay put between pulses.
    assert_hold_mid_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_i |=> $stable(act_i));

    // R2: a write in the window is read back at the same address.
    assert_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_wr_i && in_win) ##1 (host_addr_i == $past(host_addr_i))
        |-> (host_rdata_o == $past(host_wdata_i)));

    // R9: an output changes only together with its launch strobe.
    for (genvar n = 0; n < NUM_STREAMS; n++) begin : g_ser
        assert_ser_on_launch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ser_o[n] != $past(ser_o[n])) |-> launch_o[n]);
    end
endmodule

bind stream_advance_timer sat_checker #(
    .NUM_STREAMS (NUM_STREAMS),
    .REG_W       (REG_W),
    .ADDR_W      (ADDR_W),
    .BASE_ADDR   (BASE_ADDR),
    .NUM_REGS    (NUM_REGS),
    .FRAME_STEPS (FRAME_STEPS),
    .PH_W        (PH_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_i      (frame_i),
    .host_wr_i    (host_wr_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .ser_o        (ser_o),
    .launch_o     (launch_o),
    .phase_i      (phase_q),
    .act_i        (act_flat)
);

// File: tb/sim_stream_advance_timer.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_stream_advance_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NS         = 32;
    localparam int FRAME_BITS = 4;
    localparam int F          = FRAME_BITS * 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame = 1'b0;
    logic           host_wr = 1'b0;
    logic [7:0]     host_addr = 8'h00;
    logic [15:0]    host_wdata = 16'h0000;
    logic [15:0]    host_rdata;
    logic [NS-1:0]  rate16 = '0;
    logic [NS*8-1:0] tx_byte;
    logic [NS-1:0]  ser;
    logic [NS-1:0]  launch;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] shadow [4];

    always #(CLK_PERIOD / 2) clk = ~clk;

    stream_advance_timer #(
        .NUM_STREAMS (NS),
        .FRAME_BITS  (FRAME_BITS)
    ) u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .frame_i      (frame),
        .host_wr_i    (host_wr),
        .host_addr_i  (host_addr),
        .host_wdata_i (host_wdata),
        .host_rdata_o (host_rdata),
        .rate16_i     (rate16),
        .tx_byte_i    (tx_byte),
        .ser_o        (ser),
        .launch_o     (launch)
    );

    function automatic logic [7:0] byte_of(input int s);
        return 8'hB4 ^ 8'(s * 37);
    endfunction

    task automatic check(input string req, input bit ok, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic host_write(input logic [7:0] a, input logic [15:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); @(negedge clk);
        host_wr = 1'b0;
        if (a >= 8'h1C && a <= 8'h1F) shadow[a - 8'h1C] = d;
    endtask

    task automatic host_check(input string req, input logic [7:0] a, input logic [15:0] exp);
        host_addr = a;
        #1;
        check(req, host_rdata === exp, $sformatf("read addr %0h", a), host_rdata, exp);
    endtask

    task automatic set_code(input int s, input int k);
        logic [15:0] v;
        v = shadow[s / 8];
        v[2*(s%8) +: 2] = 2'(k);
        host_write(8'h1C + 8'(s / 8), v);
    endtask

    // Pulse the frame, then compare launch and data for ncyc steps.
    // A non-negative wr_at issues a host write in that step.
    task automatic run_frame(input int s, input int k, input bit r16, input int ncyc,
                             input string req, input int wr_at,
                             input logic [7:0] wa, input logic [15:0] wd);
        logic       exp_ser;
        logic [7:0] b;
        int         p;
        int         a;
        bit         exp_l;
        p = r16 ? 8 : 16;
        b = byte_of(s);
        rate16[s] = r16;
        exp_ser = ser[s];
        frame = 1'b1;
        @(posedge clk); @(negedge clk);
        frame = 1'b0;
        for (int ph = 0; ph < ncyc; ph++) begin
            a = (ph + k) % F;
            exp_l = ((a % p) == 0);
            if (exp_l) exp_ser = b[7 - ((a / p) % 8)];
            check(req, (launch[s] === exp_l) && (ser[s] === exp_ser),
                  $sformatf("stream %0d phase %0d {launch,ser}", s, ph),
                  {launch[s], ser[s]}, {exp_l, exp_ser});
            if (ph == wr_at) begin
                host_wr = 1'b1; host_addr = wa; host_wdata = wd;
                shadow[wa - 8'h1C] = wd;
            end
            @(posedge clk); @(negedge clk);
            host_wr = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R1", ser === '0, "ser after reset", ser, 0);
        check("R1", launch === '0, "launch after reset", launch, 0);
        for (int r = 0; r < 4; r++) host_check("R1", 8'h1C + 8'(r), 16'h0000);
    endtask

    task automatic t_regs();
        host_write(8'h1C, 16'h1234);
        host_write(8'h1D, 16'hABCD);
        host_write(8'h1E, 16'h0F0F);
        host_write(8'h1F, 16'hC003);
        host_check("R2", 8'h1C, 16'h1234);
        host_check("R2", 8'h1D, 16'hABCD);
        host_check("R2", 8'h1E, 16'h0F0F);
        host_check("R2", 8'h1F, 16'hC003);
        host_write(8'h1B, 16'hFFFF);
        host_write(8'h20, 16'hFFFF);
        host_check("R2", 8'h1B, 16'h0000);
        host_check("R2", 8'h20, 16'h0000);
        host_check("R2", 8'h1C, 16'h1234);
        host_check("R2", 8'h1F, 16'hC003);
        for (int r = 0; r < 4; r++) host_write(8'h1C + 8'(r), 16'h0000);
    endtask

    task automatic t_base_8m();
        run_frame(0, 0, 1'b0, F, "R4", -1, 8'h00, 16'h0);
    endtask

    task automatic t_advance_8m();
        set_code(5, 1);
        run_frame(5, 1, 1'b0, F, "R5", -1, 8'h00, 16'h0);
        set_code(12, 3);
        run_frame(12, 3, 1'b0, F, "R5 R7", -1, 8'h00, 16'h0);
    endtask

    task automatic t_advance_16m();
        set_code(20, 2);
        run_frame(20, 2, 1'b1, F, "R6", -1, 8'h00, 16'h0);
        set_code(31, 3);
        run_frame(31, 3, 1'b1, F, "R6 R7", -1, 8'h00, 16'h0);
    endtask

    task automatic t_early_pulse();
        run_frame(0, 0, 1'b0, 23, "R3", -1, 8'h00, 16'h0);
        run_frame(0, 0, 1'b0, F, "R3", -1, 8'h00, 16'h0);
    endtask

    task automatic t_mid_frame_write();
        logic [15:0] v;
        v = shadow[0];
        v[7:6] = 2'd2;
        run_frame(3, 0, 1'b0, F, "R8", 10, 8'h1C, v);
        run_frame(3, 2, 1'b0, F, "R8", -1, 8'h00, 16'h0);
    endtask

    task automatic t_independent();
        set_code(6, 2);
        rate16[6] = 1'b1;
        run_frame(5, 1, 1'b0, F, "R10", -1, 8'h00, 16'h0);
        run_frame(6, 2, 1'b1, F, "R10", -1, 8'h00, 16'h0);
        run_frame(7, 0, 1'b0, F, "R10", -1, 8'h00, 16'h0);
    endtask

    initial begin
        for (int s = 0; s < NS; s++) tx_byte[s*8 +: 8] = byte_of(s);
        for (int r = 0; r < 4; r++) shadow[r] = 16'h0000;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_base_8m();
        t_advance_8m();
        t_advance_16m();
        t_early_pulse();
        t_mid_frame_write();
        t_independent();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule